// File: doc/BRIEF.md
# Divergent Index Waterfall Sequencer

This block turns one register-relative vector move whose index can differ from lane to lane into a series of uniform moves. A start pulse captures a 64-lane execution mask, one index per lane, a scalar index, and a flag that marks the index as already uniform. The block then serves the distinct index values one after another. For each pass it gives the move unit a strobe, one scalar index, and the lane mask to use for that pass.

On each pass the sequencer picks the lowest-numbered lane still waiting and reads that lane's index. It selects every waiting lane that holds the same value and issues the move under that narrowed mask. It then removes those lanes from the waiting set, and it stops once no lane is left. The mask captured at start is kept in a save register. On the cycle that signals completion, the execution-mask output is set back to that saved value.

When the uniform flag is set, the block skips the loop: it issues exactly one move with the scalar index under the full captured mask. When the captured mask is empty, no move is issued and the block completes at once.

Top module: `wf_seq_top`

## Requirements
- R1: After reset, mv_strobe, done and busy are 0, and exec_out, mv_mask and mv_idx are all zero.
- R2: If uniform is 1 at start and the mask is nonzero, the next cycle carries exactly one strobe with mv_idx equal to scalar_idx and mv_mask equal to the captured mask. The cycle after that carries done.
- R3: The mask present at start is saved. On the done cycle, and in every idle cycle until the next start, exec_out equals that saved mask.
- R4: In the non-uniform case, each pass uses as mv_idx the index held by the lowest-numbered lane still waiting. Lane i's index is bits [i*IDX_W +: IDX_W] of idx_vec.
- R5: The mask of each pass holds exactly the waiting lanes whose index equals that pass's mv_idx, and exec_out equals that mask during the pass.
- R6: Passes occur on consecutive cycles, starting the cycle after start. Every active lane is served exactly once, and the number of passes never exceeds the number of active lanes.
- R7: done is a one-cycle pulse in the cycle right after the last pass. busy is 1 from the cycle after start through the done cycle.
- R8: With an all-zero captured mask, no strobe is issued in either mode, and done comes in the cycle after start.
- R9: A start pulse while busy is 1 is ignored: the running sequence and its saved mask are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence (accepted only when idle) |
| uniform | input | 1 | Index is uniform; issue a single move |
| scalar_idx | input | IDX_W | Index used when uniform is set |
| exec_in | input | LANES | Execution mask at start |
| idx_vec | input | LANES*IDX_W | Per-lane index, lane i at [i*IDX_W +: IDX_W] |
| mv_strobe | output | 1 | Issue a move this cycle |
| mv_idx | output | IDX_W | Scalar index for this move |
| mv_mask | output | LANES | Lanes enabled for this move |
| exec_out | output | LANES | Execution mask in force |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Original mask restored (one-cycle pulse) |

## Verification
A corrupted waiting-lane register shows up at the ports within one cycle. Either the pass mask picks up a lane that was already served, or the wrong lane is chosen as first, or the sequence ends early or runs long. Every pass is compared against a behavioural reference on the cycle it occurs. The union of all pass masks is checked against the starting mask to catch lanes that were dropped or served twice. A bad save register appears as a wrong exec_out on the done cycle and stays visible through the idle cycles that follow.

// File: rtl/wf_pkg.sv
package wf_pkg;
  typedef enum logic [1:0] {
    WF_IDLE = 2'd0,
    WF_RUN  = 2'd1,
    WF_UNI  = 2'd2,
    WF_FIN  = 2'd3
  } wf_state_e;
endpackage

// File: rtl/wf_first_lane.sv
// Lowest-numbered set bit of a request vector.
module wf_first_lane #(
  parameter int LANES = 64,
  localparam int LW = $clog2(LANES)
) (
  input  logic [LANES-1:0] req,
  output logic [LW-1:0]    lane,
  output logic             any
);
  always_comb begin
    lane = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (req[i]) lane = LW'(i);
    end
    any = |req;
  end
endmodule

// File: rtl/wf_lane_match.sv
// Per-lane equality of the lane index against one key, gated by live lanes.
module wf_lane_match #(
  parameter int LANES = 64,
  parameter int IDX_W = 5
) (
  input  logic [LANES*IDX_W-1:0] lane_idx,
  input  logic [IDX_W-1:0]       key,
  input  logic [LANES-1:0]       live,
  output logic [LANES-1:0]       hit
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign hit[g] = live[g] && (lane_idx[g*IDX_W +: IDX_W] == key);
  end
endmodule

// File: rtl/wf_seq_top.sv
module wf_seq_top #(
  parameter int LANES = 64,
  parameter int IDX_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   uniform,
  input  logic [IDX_W-1:0]       scalar_idx,
  input  logic [LANES-1:0]       exec_in,
  input  logic [LANES*IDX_W-1:0] idx_vec,
  output logic                   mv_strobe,
  output logic [IDX_W-1:0]       mv_idx,
  output logic [LANES-1:0]       mv_mask,
  output logic [LANES-1:0]       exec_out,
  output logic                   busy,
  output logic                   done
);
  import wf_pkg::*;

  localparam int LW = $clog2(LANES);
  localparam int CW = $clog2(LANES + 1) + 1;

  wf_state_e              state_q, state_d;
  logic [LANES-1:0]       save_q, rem_q, rem_d;
  logic [LANES*IDX_W-1:0] vec_q;
  logic [IDX_W-1:0]       sidx_q;
  logic                   load_en, rem_en;

  logic [LW-1:0]          first_lane;
  logic                   any_left;
  logic [IDX_W-1:0]       key;
  logic [LANES-1:0]       hit;

  wf_first_lane #(.LANES(LANES)) u_first (
    .req  (rem_q),
    .lane (first_lane),
    .any  (any_left)
  );

  assign key = vec_q[int'(first_lane)*IDX_W +: IDX_W];

  wf_lane_match #(.LANES(LANES), .IDX_W(IDX_W)) u_match (
    .lane_idx (vec_q),
    .key      (key),
    .live     (rem_q),
    .hit      (hit)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    load_en = 1'b0;
    rem_en  = 1'b0;
    unique case (state_q)
      WF_IDLE: begin
        if (start) begin
          load_en = 1'b1;
          rem_en  = 1'b1;
          rem_d   = exec_in;
          if (exec_in == '0) state_d = WF_FIN;
          else if (uniform)  state_d = WF_UNI;
          else               state_d = WF_RUN;
        end
      end
      WF_RUN: begin
        rem_en = 1'b1;
        rem_d  = rem_q ^ hit;
        if ((rem_q ^ hit) == '0 || !any_left) state_d = WF_FIN;
      end
      WF_UNI:  state_d = WF_FIN;
      WF_FIN:  state_d = WF_IDLE;
      default: state_d = WF_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WF_IDLE;
      save_q  <= '0;
      rem_q   <= '0;
      vec_q   <= '0;
      sidx_q  <= '0;
    end else begin
      state_q <= state_d;
      if (rem_en) rem_q <= rem_d;
      if (load_en) begin
        save_q <= exec_in;
        vec_q  <= idx_vec;
        sidx_q <= scalar_idx;
      end
    end
  end

  // Outputs
  always_comb begin
    mv_strobe = 1'b0;
    mv_idx    = '0;
    mv_mask   = '0;
    exec_out  = save_q;
    if (state_q == WF_RUN) begin
      mv_strobe = 1'b1;
      mv_idx    = key;
      mv_mask   = hit;
      exec_out  = hit;
    end else if (state_q == WF_UNI) begin
      mv_strobe = 1'b1;
      mv_idx    = sidx_q;
      mv_mask   = save_q;
    end
  end
  assign busy = (state_q != WF_IDLE);
  assign done = (state_q == WF_FIN);

  // Pass counter used only by the checks below
  logic [CW-1:0] pass_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       pass_cnt <= '0;
    else if (load_en)                 pass_cnt <= '0;
    else if (state_q == WF_RUN)       pass_cnt <= pass_cnt + 1'b1;
  end

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r3_done_restores: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> exec_out == save_q);
  a_r6_pass_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WF_RUN) |-> (32'(pass_cnt) + 1) <= $countones(save_q));
  a_r5_pass_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WF_RUN) |-> mv_mask != '0);
  a_r6_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WF_RUN) |=> !mv_strobe || ((mv_mask & $past(mv_mask)) == '0));
  a_r2_single_move: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WF_UNI) |=> !mv_strobe && done);
  a_r9_save_stable: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> $stable(save_q));
endmodule

// File: tb/tb_wf_seq_top.sv
module tb_wf_seq_top;
  localparam int LANES  = 64;
  localparam int IDX_W  = 5;
  localparam int PERIOD = 10;

  logic                   clk = 1'b0;
  logic                   rst_n;
  logic                   start, uniform;
  logic [IDX_W-1:0]       scalar_idx;
  logic [LANES-1:0]       exec_in;
  logic [LANES*IDX_W-1:0] idx_vec;
  logic                   mv_strobe, busy, done;
  logic [IDX_W-1:0]       mv_idx;
  logic [LANES-1:0]       mv_mask, exec_out;

  int checks = 0;
  int errors = 0;

  wf_seq_top #(.LANES(LANES), .IDX_W(IDX_W)) dut (.*);

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [IDX_W-1:0] arr [LANES];

  // Run one operation and compare every cycle against a behavioural model.
  task automatic run_op(input logic [LANES-1:0] m, input bit uni,
                        input logic [IDX_W-1:0] sidx, input bit poke);
    logic [IDX_W-1:0] q_idx [$];
    logic [LANES-1:0] q_mask [$];
    logic [LANES-1:0] rem, seen;
    int n_act;
    rem = m;
    n_act = $countones(m);
    if (m != '0 && uni) begin
      q_idx.push_back(sidx); q_mask.push_back(m);
    end else begin
      while (rem != '0) begin
        int f;
        logic [LANES-1:0] sel;
        f = 0;
        while (!rem[f]) f++;
        sel = '0;
        for (int l = 0; l < LANES; l++)
          if (rem[l] && arr[l] == arr[f]) sel[l] = 1'b1;
        q_idx.push_back(arr[f]); q_mask.push_back(sel);
        rem &= ~sel;
      end
    end
    if (!uni) chk(q_idx.size() <= n_act, "R6 pass count", 64'(q_idx.size()), 64'(n_act));
    for (int l = 0; l < LANES; l++) idx_vec[l*IDX_W +: IDX_W] = arr[l];
    exec_in = m; uniform = uni; scalar_idx = sidx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = '0;
    while (q_idx.size() > 0) begin
      logic [IDX_W-1:0] ei;
      logic [LANES-1:0] em;
      ei = q_idx.pop_front(); em = q_mask.pop_front();
      chk(mv_strobe === 1'b1, "R6 strobe", 64'(mv_strobe), 64'd1);
      chk(mv_idx === ei, uni ? "R2 index" : "R4 index", 64'(mv_idx), 64'(ei));
      chk(mv_mask === em, uni ? "R2 mask" : "R5 mask", mv_mask, em);
      if (!uni) chk(exec_out === em, "R5 exec_out", exec_out, em);
      chk(done === 1'b0 && busy === 1'b1, "R7 busy", {busy, done}, 64'd2);
      chk((seen & mv_mask) == '0, "R6 lane served twice", seen & mv_mask, '0);
      seen |= mv_mask;
      if (poke) begin
        exec_in = ~m; uniform = ~uni; start = 1'b1;  // R9: must be ignored
      end
      @(negedge clk);
      start = 1'b0;
    end
    chk(seen === m, m == '0 ? "R8 no move" : "R6 coverage", seen, m);
    chk(mv_strobe === 1'b0, "R8 strobe at done", 64'(mv_strobe), 64'd0);
    chk(done === 1'b1, "R7 done", 64'(done), 64'd1);
    chk(exec_out === m, poke ? "R9 saved mask" : "R3 restore", exec_out, m);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R7 pulse end", {busy, done}, 64'd0);
    chk(exec_out === m, "R3 idle hold", exec_out, m);
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; uniform = 1'b0; scalar_idx = '0;
    exec_in = '0; idx_vec = '0;
    for (int l = 0; l < LANES; l++) arr[l] = '0;
    repeat (3) @(negedge clk);
    chk(mv_strobe === 0 && done === 0 && busy === 0, "R1 reset ctl",
        {mv_strobe, busy, done}, 64'd0);
    chk(exec_out === '0 && mv_mask === '0 && mv_idx === '0, "R1 reset data",
        exec_out | mv_mask, '0);
    rst_n = 1'b1;
    @(negedge clk);
    // Same index everywhere, full mask
    for (int l = 0; l < LANES; l++) arr[l] = 5'd7;
    run_op('1, 1'b0, '0, 1'b0);
    // All distinct among active lanes
    for (int l = 0; l < LANES; l++) arr[l] = IDX_W'(l);
    run_op(64'h0000_0000_F0F0_0F0F, 1'b0, '0, 1'b0);
    // Repeating pattern, full mask
    for (int l = 0; l < LANES; l++) arr[l] = IDX_W'(l % 5);
    run_op('1, 1'b0, '0, 1'b0);
    // Only the top lane
    run_op(64'h8000_0000_0000_0000, 1'b0, '0, 1'b0);
    // Pseudo-random indexes and masks
    for (int t = 0; t < 6; t++) begin
      for (int l = 0; l < LANES; l++) arr[l] = IDX_W'($urandom_range(0, 3 + 4*t));
      run_op({$urandom, $urandom}, 1'b0, '0, 1'b0);
    end
    // Zero mask in both modes
    run_op('0, 1'b0, '0, 1'b0);
    run_op('0, 1'b1, 5'd9, 1'b0);
    // Uniform index
    run_op(64'h1234_5678_9ABC_DEF0, 1'b1, 5'd21, 1'b0);
    // Start while busy, both modes
    for (int l = 0; l < LANES; l++) arr[l] = IDX_W'(l % 3);
    run_op(64'h00FF_00FF_00FF_00FF, 1'b0, '0, 1'b1);
    run_op(64'hAAAA_0000_5555_0000, 1'b1, 5'd3, 1'b1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule